// File: doc/BRIEF.md
# Reloadable Down-Counter Channel with Terminal-Count Interrupt

This block is one channel of a down-counting timer/counter. Software controls it through a small register interface. The same RTL has two variants, chosen by parameter. As a 12-bit timer it counts ticks of a prescaled clock. As a 32-bit event counter it counts rising edges of an external input. When the count-enable for its variant goes from 0 to 1, the channel loads the count from the reload register. Each later tick lowers the count by one. When a tick arrives at zero, the count reloads. If the interrupt enable is set, that same edge also raises an overflow status bit and a pending-interrupt flag.

Software acknowledges an interrupt in three steps: read the control word, write zero to it, then write the saved word back. The zero write clears the pending flag. Restoring the word reloads the count and counting continues with the same settings. Reading the status word clears the overflow bit. The reload value can be changed while the channel runs, and the new value takes effect at the next wrap. A timebase register is kept as plain read/write storage and has no effect on counting.

Top module: `tcw_channel`

## Requirements
- R1: After reset the reload, control, status, interrupt, value and timebase registers all read zero, and `irqOut` is low. Register addresses: 0 reload, 1 control, 2 status, 3 interrupt, 4 value, 5 timebase.
- R2: A control write that sets the variant's count-enable while it is clear loads the count from the reload register at that clock edge. Control bits are: bit 0 interrupt enable, bit 1 timer enable, bit 2 counter enable.
- R3: While enabled, each tick lowers the count by one. While disabled, ticks are ignored and the count holds.
- R4: A tick at count zero reloads the count. With interrupt enable set, the same edge sets status bit 0 (overflow) and interrupt bit 0 (pending), and `irqOut` goes high.
- R5: With interrupt enable clear, a wrap still reloads the count but sets neither overflow nor pending.
- R6: A status read returns the overflow bit and then clears it. A status read does not change the pending flag.
- R7: Writing zero to control clears the pending flag and stops counting. Writing the saved word back reloads the count, and ticks then lower it again.
- R8: Writing the reload register while running leaves the live count unchanged. The new value is used at the next wrap.
- R9: Reload and count are WIDTH bits wide. Wider write data is truncated, and the value read back is zero-extended (all-ones written to a 12-bit channel reads 0x00000FFF).
- R10: The timer variant uses only timer enable and ticks once every PRESCALE clocks, so with reload N the first wrap comes PRESCALE*(N+1) clocks after enabling. The counter variant uses only counter enable and ticks on each rising edge of `evtIn`.
- R11: The timebase register stores and returns all 32 bits and has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| evtIn | input | 1 | External event input (counter variant) |
| irqOut | output | 1 | Pending-interrupt flag |

## Verification
Some properties are checked by assertions on every cycle. These are: a start load copies the reload value, a decrement lowers the count by exactly one, a disabled channel with no control write keeps its count, the pending flag only rises while interrupt enable is set, and a status read or a zero control write clears its bit. Other behaviour can only be shown by the bench scenarios. This covers the full acknowledge sequence and the resumed count, a mid-run reload change appearing at the next wrap, ignored ticks on the wrong enable bit, truncation on the 12-bit variant, and the exact prescaled wrap time.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int CTL_W  = 3;

  localparam logic [ADDR_W-1:0] REG_RELOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CTRL     = 3'd1;
  localparam logic [ADDR_W-1:0] REG_STATUS   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_IRQ      = 3'd3;
  localparam logic [ADDR_W-1:0] REG_VALUE    = 3'd4;
  localparam logic [ADDR_W-1:0] REG_TIMEBASE = 3'd5;

  localparam int CTL_IRQ_BIT = 0;
  localparam int CTL_TMR_BIT = 1;
  localparam int CTL_CNT_BIT = 2;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic wrapCount;
  } cntStrobe_t;
endpackage

// File: rtl/tcw_control.sv
module tcw_control
  import tcw_pkg::*;
#(
  parameter bit IS_TIMER = 1'b0,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrlWr,
  input  logic [CTL_W-1:0] wrCtrl,
  input  logic             statusRd,
  input  logic             evtIn,
  input  logic             countZero,
  output logic [CTL_W-1:0] ctrlQ,
  output logic             ovfQ,
  output logic             flagQ,
  output cntStrobe_t       strobe
);
  localparam int PSC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int EN_BIT = IS_TIMER ? CTL_TMR_BIT : CTL_CNT_BIT;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PRESCALE - 1);

  logic curEna, newEna, startLoad, tick, runTick, setEvt, zeroWr;
  logic evtQ, evtEdge, pscTick;
  logic [PSC_W-1:0] pscQ;

  assign curEna = ctrlQ[EN_BIT];
  assign newEna = wrCtrl[EN_BIT];
  assign zeroWr = ctrlWr && (wrCtrl == '0);

  // event edge detector (counter variant)
  always_ff @(posedge clk) begin
    if (rst) evtQ <= 1'b0;
    else     evtQ <= evtIn;
  end
  assign evtEdge = evtIn && !evtQ;

  // prescaler (timer variant); restarts whenever the channel is idle
  always_ff @(posedge clk) begin
    if (rst || !curEna)  pscQ <= '0;
    else if (pscTick)    pscQ <= '0;
    else                 pscQ <= pscQ + 1'b1;
  end
  assign pscTick = curEna && (pscQ == PSC_LAST);

  assign tick      = IS_TIMER ? pscTick : evtEdge;
  assign startLoad = ctrlWr && newEna && !curEna;
  assign runTick   = curEna && tick && !startLoad;

  always_comb begin
    strobe.loadCount = startLoad;
    strobe.decCount  = runTick && !countZero;
    strobe.wrapCount = runTick && countZero;
  end

  assign setEvt = strobe.wrapCount && ctrlQ[CTL_IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
      ovfQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= wrCtrl;
      if (setEvt)        ovfQ <= 1'b1;
      else if (statusRd) ovfQ <= 1'b0;
      if (setEvt)        flagQ <= 1'b1;
      else if (zeroWr)   flagQ <= 1'b0;
    end
  end

  assert_flag_needs_ena_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flagQ) |-> $past(ctrlQ[CTL_IRQ_BIT]));

  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (statusRd && !setEvt) |=> !ovfQ);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (zeroWr && !setEvt) |=> !flagQ);

  assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({strobe.loadCount, strobe.decCount, strobe.wrapCount}) <= 1);
endmodule

// File: rtl/tcw_datapath.sv
module tcw_datapath
  import tcw_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cntStrobe_t        strobe,
  input  logic              reloadWr,
  input  logic [WIDTH-1:0]  reloadData,
  input  logic              timebaseWr,
  input  logic [DATA_W-1:0] timebaseData,
  output logic [WIDTH-1:0]  reloadQ,
  output logic [WIDTH-1:0]  countQ,
  output logic [DATA_W-1:0] timebaseQ,
  output logic              countZero
);
  assign countZero = (countQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadQ   <= '0;
      timebaseQ <= '0;
    end else begin
      if (reloadWr)   reloadQ   <= reloadData;
      if (timebaseWr) timebaseQ <= timebaseData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     countQ <= '0;
    else if (strobe.loadCount || strobe.wrapCount) countQ <= reloadQ;
    else if (strobe.decCount)                    countQ <= countQ - 1'b1;
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.loadCount |=> (countQ == $past(reloadQ)));

  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.decCount |=> (countQ == $past(countQ) - 1'b1));

  assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.wrapCount |=> (countQ == $past(reloadQ)));
endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
  import tcw_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit IS_TIMER = 1'b0,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              evtIn,
  output logic              irqOut
);
  localparam int EN_BIT = IS_TIMER ? CTL_TMR_BIT : CTL_CNT_BIT;

  cntStrobe_t       strobe;
  logic [CTL_W-1:0] ctrlQ;
  logic             ovfQ, flagQ, countZero;
  logic [WIDTH-1:0] reloadQ, countQ;
  logic [DATA_W-1:0] timebaseQ;
  logic ctrlWr, reloadWr, timebaseWr, statusRd;

  assign ctrlWr     = wrEn && (addr == REG_CTRL);
  assign reloadWr   = wrEn && (addr == REG_RELOAD);
  assign timebaseWr = wrEn && (addr == REG_TIMEBASE);
  assign statusRd   = rdEn && (addr == REG_STATUS);

  tcw_control #(.IS_TIMER(IS_TIMER), .PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rst(rst), .ctrlWr(ctrlWr), .wrCtrl(wrData[CTL_W-1:0]),
    .statusRd(statusRd), .evtIn(evtIn), .countZero(countZero),
    .ctrlQ(ctrlQ), .ovfQ(ovfQ), .flagQ(flagQ), .strobe(strobe)
  );

  tcw_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reloadWr(reloadWr),
    .reloadData(wrData[WIDTH-1:0]), .timebaseWr(timebaseWr),
    .timebaseData(wrData), .reloadQ(reloadQ), .countQ(countQ),
    .timebaseQ(timebaseQ), .countZero(countZero)
  );

  always_comb begin
    case (addr)
      REG_RELOAD:   rdData = DATA_W'(reloadQ);
      REG_CTRL:     rdData = DATA_W'(ctrlQ);
      REG_STATUS:   rdData = DATA_W'(ovfQ);
      REG_IRQ:      rdData = DATA_W'(flagQ);
      REG_VALUE:    rdData = DATA_W'(countQ);
      REG_TIMEBASE: rdData = timebaseQ;
      default:      rdData = '0;
    endcase
  end

  assign irqOut = flagQ;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrlQ[EN_BIT] && !ctrlWr) |=> $stable(countQ));
endmodule

// File: tb/tcw_channel_tb.sv
module tcw_channel_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, sel = 1'b0, evtIn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdA, rdB;
  logic irqA, irqB;
  logic wrEnA, wrEnB, rdEnA, rdEnB;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign wrEnA = wrEn && !sel;
  assign wrEnB = wrEn && sel;
  assign rdEnA = rdEn && !sel;
  assign rdEnB = rdEn && sel;

  tcw_channel #(.WIDTH(32), .IS_TIMER(1'b0), .PRESCALE(4)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEnA), .rdEn(rdEnA), .addr(addr),
    .wrData(wrData), .rdData(rdA), .evtIn(evtIn), .irqOut(irqA)
  );

  tcw_channel #(.WIDTH(12), .IS_TIMER(1'b1), .PRESCALE(3)) u_dutTmr (
    .clk(clk), .rst(rst), .wrEn(wrEnB), .rdEn(rdEnB), .addr(addr),
    .wrData(wrData), .rdData(rdB), .evtIn(1'b0), .irqOut(irqB)
  );

  typedef struct {
    string       req;
    logic [31:0] exp;
    logic        dut;
  } item_t;
  item_t sbQ[$];

  // monitor: compares each register read against the queued expectation
  initial begin
    item_t it;
    logic [31:0] got;
    forever begin
      @(negedge clk);
      #1;
      if (rdEn) begin
        checks++;
        if (sbQ.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: read with no expectation, got %h expected none", rdA);
        end else begin
          it  = sbQ.pop_front();
          got = it.dut ? rdB : rdA;
          if (got !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
          end
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finishRun();
  end

  task automatic wr(input logic d, input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    sel = d; addr = a; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic d, input logic [2:0] a,
                    input logic [31:0] e);
    item_t it;
    @(negedge clk);
    it.req = req; it.exp = e; it.dut = d;
    sbQ.push_back(it);
    sel = d; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic evt();
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); evtIn = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] e);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, e);
    end
  endtask

  localparam logic [2:0] A_REL = 3'd0, A_CTL = 3'd1, A_STS = 3'd2,
                         A_IRQ = 3'd3, A_VAL = 3'd4, A_TB = 3'd5;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irqOut", {31'b0, irqA}, 32'd0);
    rd("R1 reload", 1'b0, A_REL, 32'd0);
    rd("R1 ctrl",   1'b0, A_CTL, 32'd0);
    rd("R1 status", 1'b0, A_STS, 32'd0);
    rd("R1 irq",    1'b0, A_IRQ, 32'd0);
    rd("R1 value",  1'b0, A_VAL, 32'd0);
    rd("R1 timebase", 1'b0, A_TB, 32'd0);

    // R3 disabled ignores ticks, R2 start load
    wr(1'b0, A_REL, 32'd3);
    evt();
    rd("R3 hold while disabled", 1'b0, A_VAL, 32'd0);
    wr(1'b0, A_CTL, 32'h5);
    rd("R2 load on enable", 1'b0, A_VAL, 32'd3);
    evt(); evt();
    rd("R3 two ticks", 1'b0, A_VAL, 32'd1);

    // R8 reload write while running
    wr(1'b0, A_REL, 32'd5);
    rd("R8 count undisturbed", 1'b0, A_VAL, 32'd1);
    evt();
    rd("R3 down to zero", 1'b0, A_VAL, 32'd0);
    chk("R4 no irq before wrap", {31'b0, irqA}, 32'd0);
    evt();
    chk("R4 irqOut after wrap", {31'b0, irqA}, 32'd1);
    rd("R8 wrap uses new reload", 1'b0, A_VAL, 32'd5);
    rd("R4 R6 status overflow", 1'b0, A_STS, 32'd1);
    rd("R6 status cleared by read", 1'b0, A_STS, 32'd0);
    rd("R6 pending survives status read", 1'b0, A_IRQ, 32'd1);

    // R7 acknowledge sequence
    rd("R7 saved ctrl", 1'b0, A_CTL, 32'h5);
    evt();
    rd("R7 count after extra tick", 1'b0, A_VAL, 32'd4);
    wr(1'b0, A_CTL, 32'h0);
    rd("R7 pending cleared", 1'b0, A_IRQ, 32'd0);
    chk("R7 irqOut low", {31'b0, irqA}, 32'd0);
    evt();
    rd("R7 stopped", 1'b0, A_VAL, 32'd4);
    wr(1'b0, A_CTL, 32'h5);
    rd("R7 reload on restore", 1'b0, A_VAL, 32'd5);
    evt();
    rd("R7 resumes counting", 1'b0, A_VAL, 32'd4);

    // R10 timer enable has no effect on counter variant
    wr(1'b0, A_CTL, 32'h0);
    wr(1'b0, A_CTL, 32'h2);
    evt();
    rd("R10 counter ignores timer enable", 1'b0, A_VAL, 32'd4);

    // R5 wrap without interrupt enable
    wr(1'b0, A_REL, 32'd1);
    wr(1'b0, A_CTL, 32'h0);
    wr(1'b0, A_CTL, 32'h4);
    rd("R5 loaded", 1'b0, A_VAL, 32'd1);
    evt(); evt();
    rd("R5 wrapped", 1'b0, A_VAL, 32'd1);
    rd("R5 no overflow", 1'b0, A_STS, 32'd0);
    rd("R5 no pending", 1'b0, A_IRQ, 32'd0);

    // R11 timebase storage
    wr(1'b0, A_TB, 32'hA5A5_1234);
    rd("R11 timebase readback", 1'b0, A_TB, 32'hA5A5_1234);
    rd("R11 count unaffected", 1'b0, A_VAL, 32'd1);

    // R9 truncation on the 12-bit timer
    wr(1'b1, A_REL, 32'hFFFF_FFFF);
    rd("R9 reload truncated", 1'b1, A_REL, 32'h0000_0FFF);
    wr(1'b1, A_TB, 32'hFFFF_FFFF);
    rd("R11 timer timebase full width", 1'b1, A_TB, 32'hFFFF_FFFF);

    // R10 timer ignores counter enable, then prescaled wrap time
    wr(1'b1, A_CTL, 32'h5);
    rd("R10 timer ignores counter enable", 1'b1, A_VAL, 32'd0);
    wr(1'b1, A_CTL, 32'h0);
    wr(1'b1, A_REL, 32'd2);
    wr(1'b1, A_CTL, 32'h3);
    n = 0;
    while (!irqB && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R10 prescaled wrap cycles", n, 32'd9);
    rd("R4 timer overflow", 1'b1, A_STS, 32'd1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sbQ.size(), 32'd0);
    finishRun();
  end
endmodule